// File: doc/BRIEF.md
# Windowed Bitstream Randomness Tester

This block watches a serial stream of raw random bits and grades it in fixed windows of 20,000 accepted bits. A bit counts only on a cycle where its valid strobe is high. Three statistical checks run over the same window. The ones check counts the one bits. The nibble-frequency check cuts the window into 5,000 non-overlapping 4-bit groups. It keeps one counter per group value and a running sum of the squared counts. The runs check records maximal runs of equal bits, kept apart for zeros and ones and binned by length 1 to 5 and 6-or-more.

When the last bit of a window is accepted, the block raises a one-cycle window-done pulse on the next cycle. On that same cycle it raises one fail pulse for each check whose statistic left its allowed range. All state then clears, so the next window starts fresh. Every bound is a fixed parameter. A health monitor next to an entropy source uses the pulses to decide whether the source can be trusted.

Top module: `rng_window_tester`

## Requirements
- R1: A window holds exactly WINDOW_BITS (default 20000) bits accepted on cycles with `bit_valid` high. Cycles with `bit_valid` low change no count and do not move the window end.
- R2: `win_done` is high for exactly one cycle, in the cycle after the clock edge that accepts the last bit of a window. All counters restart from zero for the next window, and no run or nibble crosses a window boundary.
- R3: `mono_fail` pulses with `win_done` when the window's count of one bits is below 9655 or above 10345. Both 9655 and 10345 pass.
- R4: The window is split into consecutive 4-bit nibbles, and the earliest bit of each nibble is its most significant bit. `poker_fail` pulses with `win_done` if the count of any of the 16 nibble values is below 200 or above 430.
- R5: `poker_fail` also pulses when the sum over the 16 values of the squared nibble counts is below 1562822 or above 1580437. This holds even when every single count is in range.
- R6: A run is a maximal stretch of equal bits, and the run open at the end of a window is closed there. Runs are counted per bit value in six length classes: 1, 2, 3, 4, 5 and 6-or-more. `runs_fail` pulses with `win_done` if any of the 12 counts leaves its class range: [2315,2685], [1114,1386], [527,723], [240,384], [103,209], [103,209].
- R7: After reset all outputs are low. No fail output is ever high on a cycle where `win_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Qualifies `bit_in` on this cycle |
| bit_in | input | 1 | Raw random bit |
| win_done | output | 1 | One-cycle pulse after the last bit of a window |
| mono_fail | output | 1 | Ones-count verdict, valid with `win_done` |
| poker_fail | output | 1 | Nibble-frequency verdict, valid with `win_done` |
| runs_fail | output | 1 | Run-length verdict, valid with `win_done` |

## Verification
A wrong internal count shows up at the ports only at the end of a window, up to 20,000 accepted bits after the fault. It appears as a wrong verdict on one of the fail pulses. A slip in the bit counter shifts the `win_done` pulse away from the cycle after the last bit, and the bench compares that against its own record of when the last bit was accepted. The bench therefore drives whole windows with known statistics, each close to or past one bound. These include exact ones-count boundaries, nibble counts that are all in range but have a sum of squares that is too low or too high, and a window with idle gaps.

// File: rtl/rtw_pkg.sv
package rtw_pkg;
    localparam int NCAT = 6;
    localparam int NIBV = 16;

    function automatic logic [2:0] run_cat(input logic [2:0] len);
        return (len >= 3'd6) ? 3'd5 : (len - 3'd1);
    endfunction
endpackage

// File: rtl/rtw_ones.sv
module rtw_ones #(
    parameter int WINDOW_BITS = 20000,
    parameter int LO          = 9655,
    parameter int HI          = 10345
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic last,
    output logic fail
);
    localparam int CW = $clog2(WINDOW_BITS + 1);

    typedef struct packed {
        logic [CW-1:0] ones;
        logic          fail;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] fin;

    always_comb begin
        st_d      = st_q;
        st_d.fail = 1'b0;
        fin       = st_q.ones + CW'(bit_in);
        if (bit_valid) begin
            st_d.ones = fin;
            if (last) begin
                st_d.fail = (int'(fin) < LO) || (int'(fin) > HI);
                st_d.ones = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail = st_q.fail;

    // R1: an idle cycle leaves the ones count untouched
    a_r1_ones_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(st_q.ones));
endmodule

// File: rtl/rtw_poker.sv
module rtw_poker import rtw_pkg::*; #(
    parameter int WINDOW_BITS = 20000,
    parameter int CNT_LO      = 200,
    parameter int CNT_HI      = 430,
    parameter int SQ_LO       = 1562822,
    parameter int SQ_HI       = 1580437
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic last,
    output logic fail
);
    localparam int NNIB = WINDOW_BITS / 4;
    localparam int CNTW = $clog2(NNIB + 1);
    localparam int SQW  = $clog2(NNIB * NNIB + 1);

    typedef struct packed {
        logic [2:0]                 sh;
        logic [1:0]                 ph;
        logic [NIBV-1:0][CNTW-1:0]  cnt;
        logic [SQW-1:0]             sq;
        logic                       fail;
    } st_t;

    st_t st_d, st_q;
    logic [3:0]      nib;
    logic [CNTW-1:0] old;
    logic            bad;

    always_comb begin
        st_d      = st_q;
        st_d.fail = 1'b0;
        nib       = {st_q.sh, bit_in};
        old       = st_q.cnt[nib];
        bad       = 1'b0;
        if (bit_valid) begin
            st_d.sh = {st_q.sh[1:0], bit_in};
            st_d.ph = st_q.ph + 2'd1;
            if (st_q.ph == 2'd3) begin
                st_d.cnt[nib] = old + CNTW'(1);
                st_d.sq       = st_q.sq + SQW'({old, 1'b1});
            end
            if (last) begin
                for (int i = 0; i < NIBV; i++) begin
                    if ((int'(st_d.cnt[i]) < CNT_LO) || (int'(st_d.cnt[i]) > CNT_HI))
                        bad = 1'b1;
                end
                if ((int'(st_d.sq) < SQ_LO) || (int'(st_d.sq) > SQ_HI))
                    bad = 1'b1;
                st_d.fail = bad;
                st_d.cnt  = '0;
                st_d.sq   = '0;
                st_d.sh   = '0;
                st_d.ph   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail = st_q.fail;

    // R4: the square sum moves only when a nibble completes
    a_r4_sum_on_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && st_q.ph != 2'd3) |=> $stable(st_q.sq));
endmodule

// File: rtl/rtw_runs.sv
module rtw_runs import rtw_pkg::*; #(
    parameter int WINDOW_BITS  = 20000,
    parameter int RUN_LO [NCAT] = '{2315, 1114, 527, 240, 103, 103},
    parameter int RUN_HI [NCAT] = '{2685, 1386, 723, 384, 209, 209}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    input  logic last,
    output logic fail
);
    localparam int CW = $clog2(WINDOW_BITS + 1);

    typedef struct packed {
        logic                          cur;
        logic [2:0]                    len;
        logic [1:0][NCAT-1:0][CW-1:0]  cnt;
        logic                          fail;
    } st_t;

    st_t  st_d, st_q;
    logic bad;

    always_comb begin
        st_d      = st_q;
        st_d.fail = 1'b0;
        bad       = 1'b0;
        if (bit_valid) begin
            if (st_q.len == 3'd0) begin
                st_d.cur = bit_in;
                st_d.len = 3'd1;
            end else if (bit_in == st_q.cur) begin
                if (st_q.len != 3'd6) st_d.len = st_q.len + 3'd1;
            end else begin
                st_d.cnt[st_q.cur][run_cat(st_q.len)] =
                    st_q.cnt[st_q.cur][run_cat(st_q.len)] + CW'(1);
                st_d.cur = bit_in;
                st_d.len = 3'd1;
            end
            if (last) begin
                st_d.cnt[st_d.cur][run_cat(st_d.len)] =
                    st_d.cnt[st_d.cur][run_cat(st_d.len)] + CW'(1);
                for (int v = 0; v < 2; v++) begin
                    for (int k = 0; k < NCAT; k++) begin
                        if ((int'(st_d.cnt[v][k]) < RUN_LO[k]) ||
                            (int'(st_d.cnt[v][k]) > RUN_HI[k]))
                            bad = 1'b1;
                    end
                end
                st_d.fail = bad;
                st_d.cnt  = '0;
                st_d.len  = 3'd0;
                st_d.cur  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail = st_q.fail;

    // R6: the run length tracker saturates at the 6-or-more class
    a_r6_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len <= 3'd6);
endmodule

// File: rtl/rng_window_tester.sv
module rng_window_tester import rtw_pkg::*; #(
    parameter int WINDOW_BITS   = 20000,
    parameter int MONO_LO       = 9655,
    parameter int MONO_HI       = 10345,
    parameter int POK_CNT_LO    = 200,
    parameter int POK_CNT_HI    = 430,
    parameter int POK_SQ_LO     = 1562822,
    parameter int POK_SQ_HI     = 1580437,
    parameter int RUN_LO [NCAT] = '{2315, 1114, 527, 240, 103, 103},
    parameter int RUN_HI [NCAT] = '{2685, 1386, 723, 384, 209, 209}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic win_done,
    output logic mono_fail,
    output logic poker_fail,
    output logic runs_fail
);
    localparam int CW = $clog2(WINDOW_BITS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t  st_d, st_q;
    logic last;

    assign last = bit_valid && (st_q.cnt == CW'(WINDOW_BITS - 1));

    always_comb begin
        st_d      = st_q;
        st_d.done = last;
        if (last)           st_d.cnt = '0;
        else if (bit_valid) st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_done = st_q.done;

    rtw_ones #(.WINDOW_BITS(WINDOW_BITS), .LO(MONO_LO), .HI(MONO_HI)) u_ones (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .last(last), .fail(mono_fail));

    rtw_poker #(.WINDOW_BITS(WINDOW_BITS), .CNT_LO(POK_CNT_LO), .CNT_HI(POK_CNT_HI),
                .SQ_LO(POK_SQ_LO), .SQ_HI(POK_SQ_HI)) u_poker (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .last(last), .fail(poker_fail));

    rtw_runs #(.WINDOW_BITS(WINDOW_BITS), .RUN_LO(RUN_LO), .RUN_HI(RUN_HI)) u_runs (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .last(last), .fail(runs_fail));

    // R7: a verdict never appears without the window-done pulse
    a_r7_fail_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mono_fail || poker_fail || runs_fail) |-> win_done);

    // R2: the done pulse lasts exactly one cycle
    a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    // R2: the done pulse follows an accepted bit
    a_r2_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(bit_valid));

    // R1: the position counter stays inside the window
    a_r1_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) < WINDOW_BITS);
endmodule

// File: tb/rng_window_tester_tb.sv
module rng_window_tester_tb;
    localparam int NB = 20000;
    localparam int MLO = 9655, MHI = 10345;
    localparam int PLO = 200, PHI = 430;
    localparam longint SLO = 1562822, SHI = 1580437;
    localparam int RLO [6] = '{2315, 1114, 527, 240, 103, 103};
    localparam int RHI [6] = '{2685, 1386, 723, 384, 209, 209};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic is_last = 1'b0;
    logic win_done, mono_fail, poker_fail, runs_fail;
    logic acc_last_q = 1'b0;

    typedef struct { logic m; logic p; logic r; string name; } exp_t;
    exp_t exp_q[$];

    logic win [NB];
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    rng_window_tester u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .win_done(win_done), .mono_fail(mono_fail),
        .poker_fail(poker_fail), .runs_fail(runs_fail));

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    // scoreboard reference, computed from the requirement text
    task automatic make_expect(input string name);
        exp_t e;
        int ones = 0;
        int nc [16];
        int rc [2][6];
        longint sq = 0;
        logic cur;
        int len;
        e.name = name;
        foreach (nc[i]) nc[i] = 0;
        for (int v = 0; v < 2; v++) for (int k = 0; k < 6; k++) rc[v][k] = 0;
        for (int i = 0; i < NB; i++) if (win[i]) ones++;
        for (int i = 0; i < NB / 4; i++)
            nc[{win[4*i], win[4*i+1], win[4*i+2], win[4*i+3]}]++;
        cur = win[0];
        len = 1;
        for (int i = 1; i < NB; i++) begin
            if (win[i] == cur) len++;
            else begin
                rc[cur][(len >= 6) ? 5 : len - 1]++;
                cur = win[i];
                len = 1;
            end
        end
        rc[cur][(len >= 6) ? 5 : len - 1]++;
        e.m = (ones < MLO) || (ones > MHI);
        e.p = 1'b0;
        foreach (nc[i]) begin
            if ((nc[i] < PLO) || (nc[i] > PHI)) e.p = 1'b1;
            sq += longint'(nc[i]) * nc[i];
        end
        if ((sq < SLO) || (sq > SHI)) e.p = 1'b1;
        e.r = 1'b0;
        for (int v = 0; v < 2; v++)
            for (int k = 0; k < 6; k++)
                if ((rc[v][k] < RLO[k]) || (rc[v][k] > RHI[k])) e.r = 1'b1;
        exp_q.push_back(e);
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < NB; i++) begin
            case (mode)
                0: win[i] = 1'($urandom);
                1: win[i] = 1'b0;
                2: win[i] = (i < 9655);
                3: win[i] = (i < 10346);
                default: win[i] = 1'b0;
            endcase
        end
        if (mode >= 4) begin
            for (int n = 0; n < NB / 4; n++) begin
                logic [3:0] v;
                if (mode == 4) v = 4'(n % 16);
                else v = (n < 3096) ? 4'(n % 8) : 4'(8 + (n - 3096) % 8);
                for (int j = 0; j < 4; j++) win[4*n+j] = v[3-j];
            end
        end
    endtask

    task automatic drive_window(input int mode, input bit gaps, input string name);
        fill(mode);
        make_expect(name);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            while (gaps && ($urandom % 8 == 0)) begin
                bit_valid = 1'b0;
                is_last = 1'b0;
                bit_in = 1'($urandom);
                @(negedge clk);
            end
            bit_valid = 1'b1;
            bit_in = win[i];
            is_last = (i == NB - 1);
        end
        @(negedge clk);
        bit_valid = 1'b0;
        is_last = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        acc_last_q <= rst_n && bit_valid && is_last;
        cyc <= cyc + 1;
        if (cyc > 195000) begin
            bad++;
            total++;
            $display("FAIL watchdog R2 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor: pops scoreboard entries on each window-done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (win_done || acc_last_q)
                chk("R2 done one cycle after last accepted bit", win_done, acc_last_q);
            if (!win_done)
                chk("R7 no verdict without done", mono_fail | poker_fail | runs_fail, 1'b0);
            if (win_done) begin
                if (exp_q.size() == 0) chk("R1 unexpected window end", 1'b1, 1'b0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({"R3 ones verdict ", e.name}, mono_fail, e.m);
                    chk({"R4/R5 nibble verdict ", e.name}, poker_fail, e.p);
                    chk({"R6 runs verdict ", e.name}, runs_fail, e.r);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R7 reset done low", win_done, 1'b0);
        chk("R7 reset fails low", mono_fail | poker_fail | runs_fail, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 idle after reset", win_done, 1'b0);
        drive_window(0, 1'b1, "random with idle gaps R1");
        drive_window(1, 1'b0, "all zeros");
        drive_window(2, 1'b0, "ones at lower bound R3");
        drive_window(3, 1'b0, "ones above upper bound R3");
        drive_window(4, 1'b0, "uniform nibbles low square sum R5");
        drive_window(5, 1'b0, "skewed nibbles high square sum R5");
        drive_window(0, 1'b0, "random after restart R2");
        chk("R1 no pending window", 1'(exp_q.size() != 0), 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule